// File: doc/BRIEF.md
# Receive Address Filter and Error-Bit Policy for a Consumer-Electronics Control Bus

This block sits behind the bit decoder of a single-wire consumer-electronics control bus receiver. When the header of a new message has been decoded, it takes the four-bit destination address and decides two things. First, whether the receiver takes the message at all. Second, whether the receiver pulls the acknowledge slot. It keeps that decision as the state of the open message until the message ends or reception is stopped.

While a message is open, the bit decoder may report three kinds of timing fault: a rising edge at the wrong moment, a bit period that is too short, or one that is too long. For each fault the block decides whether reception ends and whether an error bit is forced onto the bus. The decision depends on configuration enables, on the listening mode, and on a broadcast override that takes precedence over the per-fault enables.

Top module: `cec_rx_filter`

## Requirements
- R1: The own-address map has one bit per logical address; bit k selects address k (k = 0..14). Any number of bits may be set at once. A header whose destination d has map bit d set makes `accept` and `ack_drive` both 1, one clock after `hdr_vld`.
- R2: In reduced listening (`cfg_full_listen` = 0), a header to a non-broadcast address whose map bit is clear gives `accept` = 0 and `ack_drive` = 0. Error strobes during such a message give no `errbit_gen` and no `stop_rx`.
- R3: Destination 4'hF is broadcast. It is always accepted, in either listening mode, and is never acknowledged (`ack_drive` = 0).
- R4: In full listening (`cfg_full_listen` = 1), a header to a foreign address gives `accept` = 1 with `ack_drive` = 0. A header to an own address is still acknowledged.
- R5: A rising-edge fault in an accepted message pulses `stop_rx` exactly when `cfg_stop_on_rise` = 1. In that case `accept` and `ack_drive` are 0 in the cycle of the pulse. With the option clear, the message stays accepted.
- R6: In a non-broadcast message, a rising-edge fault pulses `errbit_gen` only when `cfg_rise_eb_en` = 1 and `cfg_stop_on_rise` = 1.
- R7: In a non-broadcast message, a long-period fault pulses `errbit_gen` exactly when `cfg_long_eb_en` = 1.
- R8: In a broadcast message with `cfg_bcast_quiet` = 0, the per-fault enables are overridden. A rising-edge fault with `cfg_stop_on_rise` = 1 pulses `errbit_gen` even if `cfg_rise_eb_en` = 0. A long-period fault pulses it even if `cfg_long_eb_en` = 0.
- R9: In a broadcast message with `cfg_bcast_quiet` = 1, rising-edge and long-period faults give no `errbit_gen`. A short-period fault gives no error bit when `cfg_full_listen` = 1, and gives one when `cfg_full_listen` = 0.
- R10: In a non-broadcast accepted message, a short-period fault pulses `errbit_gen`.
- R11: `stop_rx` and `errbit_gen` are registered single-cycle pulses, high in the cycle after the fault strobe and low in the cycle after that.
- R12: After reset, all outputs are 0. A `msg_done` strobe makes `accept` and `ack_drive` 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_vld | input | 1 | Header decoded strobe |
| hdr_dst | input | 4 | Destination address of the header |
| msg_done | input | 1 | End-of-message strobe |
| err_rise | input | 1 | Rising-edge timing fault strobe |
| err_short | input | 1 | Short bit period fault strobe |
| err_long | input | 1 | Long bit period fault strobe |
| cfg_full_listen | input | 1 | 1: full listening, 0: reduced listening |
| cfg_own_map | input | 15 | Own logical address bitmap |
| cfg_stop_on_rise | input | 1 | Rising-edge fault ends reception |
| cfg_rise_eb_en | input | 1 | Error bit on rising-edge fault |
| cfg_long_eb_en | input | 1 | Error bit on long-period fault |
| cfg_bcast_quiet | input | 1 | Suppress error bits in broadcast messages |
| accept | output | 1 | Current message is received |
| ack_drive | output | 1 | Receiver acknowledges the current message |
| stop_rx | output | 1 | Pulse: reception ends |
| errbit_gen | output | 1 | Pulse: force an error bit on the bus |

## Verification
The assertions take for granted that the bit decoder raises at most one fault strobe per cycle. They also take for granted that no fault strobe shares a cycle with `hdr_vld` or `msg_done`, and that configuration is held steady while a message is open. The directed stimulus changes configuration only between messages. It issues header, fault and end strobes on separate cycles, one at a time, so every check sees a single cause.

// File: rtl/cec_rxf_pkg.sv
package cec_rxf_pkg;
  // Destination address width on the bus header
  localparam int unsigned ADDR_W  = 4;
  // All-ones address is the broadcast address
  localparam int unsigned BCAST_A = (1 << ADDR_W) - 1;
  // One own-address bit per non-broadcast logical address
  localparam int unsigned N_OWN   = BCAST_A;

  typedef struct packed {
    logic              full_listen;
    logic              stop_on_rise;
    logic              rise_eb_en;
    logic              long_eb_en;
    logic              bcast_quiet;
    logic [N_OWN-1:0]  own_map;
  } rxf_cfg_t;

  typedef struct packed {
    logic rise;
    logic short_p;
    logic long_p;
  } rxf_err_t;
endpackage

// File: rtl/cec_rxf_addr_match.sv
module cec_rxf_addr_match
  import cec_rxf_pkg::*;
(
  input  logic [ADDR_W-1:0] dst,
  input  logic [N_OWN-1:0]  own_map,
  input  logic              full_listen,
  output logic              hit_own,
  output logic              is_bcast,
  output logic              take
);
  logic [N_OWN-1:0] hit_vec;

  // one comparator per logical address
  for (genvar k = 0; k < N_OWN; k++) begin : g_slot
    assign hit_vec[k] = own_map[k] && (dst == ADDR_W'(k));
  end

  always_comb begin
    is_bcast = (dst == ADDR_W'(BCAST_A));
    hit_own  = |hit_vec;
    take     = is_bcast || hit_own || full_listen;
  end
endmodule

// File: rtl/cec_rxf_session.sv
module cec_rxf_session
  import cec_rxf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hdr_vld,
  input  logic take,
  input  logic hit_own,
  input  logic is_bcast,
  input  logic close_req,
  output logic sess_acc,
  output logic sess_ack,
  output logic sess_bc
);
  logic acc_nxt, ack_nxt, bc_nxt, upd_en;

  always_comb begin
    upd_en  = hdr_vld || close_req;
    acc_nxt = 1'b0;
    ack_nxt = 1'b0;
    bc_nxt  = 1'b0;
    if (hdr_vld) begin
      acc_nxt = take;
      ack_nxt = hit_own && !is_bcast;
      bc_nxt  = is_bcast;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_acc <= 1'b0;
      sess_ack <= 1'b0;
      sess_bc  <= 1'b0;
    end else if (upd_en) begin
      sess_acc <= acc_nxt;
      sess_ack <= ack_nxt;
      sess_bc  <= bc_nxt;
    end
  end

  a_r4_ack_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    sess_ack |-> sess_acc);

  a_r3_bcast_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    sess_bc |-> !sess_ack);
endmodule

// File: rtl/cec_rxf_errpol.sv
module cec_rxf_errpol
  import cec_rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sess_acc,
  input  logic     sess_bc,
  input  rxf_err_t err,
  input  rxf_cfg_t cfg,
  output logic     stop_req,
  output logic     stop_rx,
  output logic     errbit_gen
);
  logic rise_eb, long_eb, short_eb, eb_nxt;

  always_comb begin
    if (sess_bc) begin
      // broadcast override replaces the per-fault enables
      rise_eb  = !cfg.bcast_quiet && cfg.stop_on_rise;
      long_eb  = !cfg.bcast_quiet;
      short_eb = !(cfg.bcast_quiet && cfg.full_listen);
    end else begin
      rise_eb  = cfg.rise_eb_en && cfg.stop_on_rise;
      long_eb  = cfg.long_eb_en;
      short_eb = 1'b1;
    end
    stop_req = sess_acc && err.rise && cfg.stop_on_rise;
    eb_nxt   = sess_acc && ((err.rise    && rise_eb) ||
                            (err.long_p  && long_eb) ||
                            (err.short_p && short_eb));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_rx    <= 1'b0;
      errbit_gen <= 1'b0;
    end else begin
      stop_rx    <= stop_req;
      errbit_gen <= eb_nxt;
    end
  end

  a_r11_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({err.rise, err.short_p, err.long_p}) <= 1);

  a_r11_eb_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    errbit_gen |-> $past(err.rise || err.short_p || err.long_p));

  a_r2_eb_needs_session: assert property (@(posedge clk) disable iff (!rst_n)
    errbit_gen |-> $past(sess_acc));

  a_r5_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rx |-> $past(err.rise && cfg.stop_on_rise));

  a_r9_quiet_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (errbit_gen && $past(sess_bc && cfg.bcast_quiet)) |->
      $past(err.short_p && !cfg.full_listen));
endmodule

// File: rtl/cec_rx_filter.sv
module cec_rx_filter
  import cec_rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_vld,
  input  logic [ADDR_W-1:0] hdr_dst,
  input  logic              msg_done,
  input  logic              err_rise,
  input  logic              err_short,
  input  logic              err_long,
  input  logic              cfg_full_listen,
  input  logic [N_OWN-1:0]  cfg_own_map,
  input  logic              cfg_stop_on_rise,
  input  logic              cfg_rise_eb_en,
  input  logic              cfg_long_eb_en,
  input  logic              cfg_bcast_quiet,
  output logic              accept,
  output logic              ack_drive,
  output logic              stop_rx,
  output logic              errbit_gen
);
  rxf_cfg_t cfg;
  rxf_err_t err;
  logic hit_own, is_bcast, take, stop_req, sess_bc;

  always_comb begin
    cfg.full_listen  = cfg_full_listen;
    cfg.stop_on_rise = cfg_stop_on_rise;
    cfg.rise_eb_en   = cfg_rise_eb_en;
    cfg.long_eb_en   = cfg_long_eb_en;
    cfg.bcast_quiet  = cfg_bcast_quiet;
    cfg.own_map      = cfg_own_map;
    err.rise         = err_rise;
    err.short_p      = err_short;
    err.long_p       = err_long;
  end

  cec_rxf_addr_match u_match (
    .dst         (hdr_dst),
    .own_map     (cfg_own_map),
    .full_listen (cfg_full_listen),
    .hit_own     (hit_own),
    .is_bcast    (is_bcast),
    .take        (take)
  );

  cec_rxf_session u_sess (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_vld   (hdr_vld),
    .take      (take),
    .hit_own   (hit_own),
    .is_bcast  (is_bcast),
    .close_req (msg_done || stop_req),
    .sess_acc  (accept),
    .sess_ack  (ack_drive),
    .sess_bc   (sess_bc)
  );

  cec_rxf_errpol u_pol (
    .clk        (clk),
    .rst_n      (rst_n),
    .sess_acc   (accept),
    .sess_bc    (sess_bc),
    .err        (err),
    .cfg        (cfg),
    .stop_req   (stop_req),
    .stop_rx    (stop_rx),
    .errbit_gen (errbit_gen)
  );

  a_r5_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rx |-> !accept);

  a_r12_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(msg_done) && !$past(hdr_vld)) |-> !accept);
endmodule

// File: tb/cec_rx_filter_bench.sv
module cec_rx_filter_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic hdr_vld, msg_done, err_rise, err_short, err_long;
  logic [3:0]  hdr_dst;
  logic        cfg_full_listen, cfg_stop_on_rise, cfg_rise_eb_en;
  logic        cfg_long_eb_en, cfg_bcast_quiet;
  logic [14:0] cfg_own_map;
  logic accept, ack_drive, stop_rx, errbit_gen;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cec_rx_filter u_cec_rx_filter (
    .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr_dst(hdr_dst),
    .msg_done(msg_done), .err_rise(err_rise), .err_short(err_short),
    .err_long(err_long), .cfg_full_listen(cfg_full_listen),
    .cfg_own_map(cfg_own_map), .cfg_stop_on_rise(cfg_stop_on_rise),
    .cfg_rise_eb_en(cfg_rise_eb_en), .cfg_long_eb_en(cfg_long_eb_en),
    .cfg_bcast_quiet(cfg_bcast_quiet), .accept(accept),
    .ack_drive(ack_drive), .stop_rx(stop_rx), .errbit_gen(errbit_gen)
  );

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic fl, input logic stp, input logic ren,
                         input logic len, input logic q, input logic [14:0] own);
    @(negedge clk);
    cfg_full_listen = fl; cfg_stop_on_rise = stp; cfg_rise_eb_en = ren;
    cfg_long_eb_en = len; cfg_bcast_quiet = q; cfg_own_map = own;
  endtask

  // kind: 0 none, 1 rising-edge, 2 short, 3 long
  task automatic run_msg(input string req, input logic [3:0] dst, input int kind,
                         input logic e_acc, input logic e_ack,
                         input logic e_stop, input logic e_eb);
    @(negedge clk); hdr_vld = 1'b1; hdr_dst = dst;
    @(negedge clk); hdr_vld = 1'b0;
    chk(req, "accept", accept, e_acc);
    chk(req, "ack_drive", ack_drive, e_ack);
    if (kind != 0) begin
      err_rise = (kind == 1); err_short = (kind == 2); err_long = (kind == 3);
      @(negedge clk); err_rise = 1'b0; err_short = 1'b0; err_long = 1'b0;
      chk(req, "stop_rx", stop_rx, e_stop);
      chk(req, "errbit_gen", errbit_gen, e_eb);
      chk(req, "accept after fault", accept, e_acc && !e_stop);
      @(negedge clk);
      chk("R11", "stop_rx pulse end", stop_rx, 1'b0);
      chk("R11", "errbit_gen pulse end", errbit_gen, 1'b0);
    end
    @(negedge clk); msg_done = 1'b1;
    @(negedge clk); msg_done = 1'b0;
    chk("R12", "accept after done", accept, 1'b0);
    chk("R12", "ack after done", ack_drive, 1'b0);
  endtask

  task automatic t_reset;
    chk("R12", "reset accept", accept, 1'b0);
    chk("R12", "reset ack", ack_drive, 1'b0);
    chk("R12", "reset stop", stop_rx, 1'b0);
    chk("R12", "reset errbit", errbit_gen, 1'b0);
  endtask

  task automatic t_own_multi;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0210);
    run_msg("R1", 4'd4, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_msg("R1", 4'd9, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_msg("R2", 4'd5, 0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reduced_ignore;
    set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 15'h0010);
    run_msg("R2", 4'd2, 3, 1'b0, 1'b0, 1'b0, 1'b0);
    run_msg("R2", 4'd2, 1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_bcast;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 15'h7FFF);
    run_msg("R3", 4'hF, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0000);
    run_msg("R3", 4'hF, 0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_full_listen;
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0010);
    run_msg("R4", 4'd3, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_msg("R4", 4'd4, 0, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_rise;
    set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 15'h0010);
    run_msg("R6", 4'd4, 1, 1'b1, 1'b1, 1'b1, 1'b1);
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 15'h0010);
    run_msg("R5", 4'd4, 1, 1'b1, 1'b1, 1'b0, 1'b0);
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 15'h0010);
    run_msg("R6", 4'd4, 1, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_long;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 15'h0001);
    run_msg("R7", 4'd0, 3, 1'b1, 1'b1, 1'b0, 1'b1);
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0001);
    run_msg("R7", 4'd0, 3, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_short_directed;
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 15'h4000);
    run_msg("R10", 4'd14, 2, 1'b1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_bcast_loud;
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 15'h0000);
    run_msg("R8", 4'hF, 1, 1'b1, 1'b0, 1'b1, 1'b1);
    run_msg("R8", 4'hF, 3, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_bcast_quiet;
    set_cfg(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 15'h0000);
    run_msg("R9", 4'hF, 1, 1'b1, 1'b0, 1'b1, 1'b0);
    run_msg("R9", 4'hF, 3, 1'b1, 1'b0, 1'b0, 1'b0);
    run_msg("R9", 4'hF, 2, 1'b1, 1'b0, 1'b0, 1'b0);
    set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 15'h0000);
    run_msg("R9", 4'hF, 2, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hdr_vld = 1'b0; hdr_dst = 4'd0; msg_done = 1'b0;
    err_rise = 1'b0; err_short = 1'b0; err_long = 1'b0;
    cfg_full_listen = 1'b0; cfg_stop_on_rise = 1'b0; cfg_rise_eb_en = 1'b0;
    cfg_long_eb_en = 1'b0; cfg_bcast_quiet = 1'b0; cfg_own_map = 15'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_own_multi;
    t_reduced_ignore;
    t_bcast;
    t_full_listen;
    t_rise;
    t_long;
    t_short_directed;
    t_bcast_loud;
    t_bcast_quiet;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule